// File: doc/BRIEF.md
# Filter Output Scaling Stage

This block sits between a digital control filter and a pulse-width modulator. It takes the filter's signed 24-bit result and turns it into two timing values for the modulator: a duty time in 14.4 fixed point, whose four fractional bits feed the high-resolution edge logic, and a 14-bit integer period time. One multiplier does both calculations, one after the other. The duty calculation runs first and the period calculation runs second.

Each pass multiplies the captured filter value by a 14-bit unsigned scale factor. A two-bit index picks the duty factor from four programmable values, and a one-bit index picks the period factor from two. The signed product is floored at zero. It is then rounded half-up to 18 bits by dropping its 19 low bits. The duty result is limited by a programmable ceiling and floor. The period result is not limited; only its four fractional bits are dropped. A single-cycle done pulse marks the cycle in which both outputs take their new values together.

Top module: `filter_out_scaler`

## Requirements
- R1: After reset, dutyOut, periodOut and done are 0, all six scale factors are 0, the duty ceiling is 0x3FFFF and the duty floor is 0.
- R2: A write with cfgWrEn high stores cfgWrData at cfgWrAddr on the next clock edge. Addresses 0 to 3 hold the duty factors (low 14 bits of the data). Addresses 4 and 5 hold the period factors (low 14 bits). Address 6 holds the duty ceiling and address 7 holds the duty floor (18 bits each).
- R3: A start sampled while idle captures filterIn, dutySel and periodSel. Later changes on those inputs do not affect the run. done is high in the second cycle after the start edge, and dutyOut and periodOut take their new values on that same edge.
- R4: A start sampled while a run is in progress is ignored. The run finishes with results from the first capture, and no second done follows.
- R5: When the signed product of filterIn and the factor is negative, the value before clamping is 0.
- R6: The rounded value is floor((P + 2^18) / 2^19) for a non-negative product P, saturating at 0x3FFFF.
- R7: The duty value is first limited to at most the ceiling and then raised to at least the floor, so the floor wins when the floor is above the ceiling.
- R8: periodOut is bits 17:4 of the rounded period-pass value, with no clamp applied.
- R9: dutySel selects duty factor 0 to 3, and periodSel selects period factor 0 or 1.
- R10: A filter value of 0x400000 with a factor of 2500 gives a duty output of 0x4E20 and a period output of 0x4E2.
- R11: done lasts exactly one cycle for each accepted start. Both outputs hold their values between runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrAddr | input | 3 | Configuration register index |
| cfgWrData | input | 18 | Configuration write data |
| start | input | 1 | Begin a two-pass conversion |
| filterIn | input | 24 | Signed filter result |
| dutySel | input | 2 | Duty scale factor index |
| periodSel | input | 1 | Period scale factor index |
| dutyOut | output | 18 | Clamped duty time, 14.4 fixed point |
| periodOut | output | 14 | Period time, integer |
| done | output | 1 | One-cycle pulse when outputs update |

## Verification
The bench targets four corner cases:
- Products exactly at the half-LSB boundary of 2^18 and one step below it. A design that truncates, or rounds at the wrong bit, yields 0 where 1 is due.
- The largest positive and most negative filter values. A sign-extension or zero-floor mistake there produces huge garbage instead of 0 or the true maximum.
- Duty clamps with the floor above the ceiling. A design that applies the two limits in the other order returns the ceiling.
- A second start and input changes during a run. A design that re-captures inputs, or restarts, reports results from the wrong operands or emits an extra done.

// File: rtl/fos_pkg.sv
`timescale 1ns/1ps
package fos_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DUTY   = 2'd1,
    ST_PERIOD = 2'd2
  } fosState_t;

  typedef struct packed {
    logic capture;     // latch operands and selections
    logic dutyPass;    // multiplier uses duty factor, result held
    logic periodPass;  // multiplier uses period factor, outputs loaded
  } fosStrobe_t;
endpackage

// File: rtl/fos_ctrl.sv
`timescale 1ns/1ps
module fos_ctrl
  import fos_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output fosStrobe_t strb,
  output logic       done
);
  fosState_t state;

  always_comb begin
    strb.capture    = start && (state == ST_IDLE);
    strb.dutyPass   = (state == ST_DUTY);
    strb.periodPass = (state == ST_PERIOD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= strb.periodPass;
      unique case (state)
        ST_IDLE:   if (start) state <= ST_DUTY;
        ST_DUTY:   state <= ST_PERIOD;
        ST_PERIOD: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  // R3: duty pass is always followed by the period pass
  p_duty_then_period_r3: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_DUTY |=> state == ST_PERIOD);

  // R4: a start during the period pass does not re-enter the sequence
  p_period_returns_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_PERIOD |=> state == ST_IDLE && done);

  // R11: done never lasts two cycles
  p_done_single_r11: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
endmodule

// File: rtl/fos_datapath.sv
`timescale 1ns/1ps
module fos_datapath
  import fos_pkg::*;
#(
  parameter int IN_W   = 24,
  parameter int FAC_W  = 14,
  parameter int OUT_W  = 18,
  parameter int FRAC_W = 4,
  parameter int N_DUTY = 4,
  parameter int N_PER  = 2,
  localparam int ADDR_W = $clog2(N_DUTY + N_PER + 2),
  localparam int DSEL_W = $clog2(N_DUTY),
  localparam int PSEL_W = $clog2(N_PER)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  fosStrobe_t                strb,
  input  logic                      cfgWrEn,
  input  logic [ADDR_W-1:0]         cfgWrAddr,
  input  logic [OUT_W-1:0]          cfgWrData,
  input  logic [IN_W-1:0]           filterIn,
  input  logic [DSEL_W-1:0]         dutySel,
  input  logic [PSEL_W-1:0]         periodSel,
  output logic [OUT_W-1:0]          dutyOut,
  output logic [OUT_W-FRAC_W-1:0]   periodOut
);
  localparam int PROD_W   = IN_W + FAC_W;
  localparam int MAG_W    = PROD_W - 1;
  localparam int SHIFT    = MAG_W - OUT_W;
  localparam int HI_ADDR  = N_DUTY + N_PER;
  localparam int LO_ADDR  = N_DUTY + N_PER + 1;
  localparam logic [MAG_W:0] HALF = (MAG_W+1)'(1) << (SHIFT - 1);

  logic [FAC_W-1:0]  dutyFac [N_DUTY];
  logic [FAC_W-1:0]  perFac  [N_PER];
  logic [OUT_W-1:0]  clampHi, clampLo;
  logic [IN_W-1:0]   filtReg;
  logic [DSEL_W-1:0] dutySelR;
  logic [PSEL_W-1:0] perSelR;
  logic [OUT_W-1:0]  dutyHold;

  // configuration storage
  for (genvar gi = 0; gi < N_DUTY; gi++) begin : g_dutyFac
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) dutyFac[gi] <= '0;
      else if (cfgWrEn && cfgWrAddr == ADDR_W'(gi)) dutyFac[gi] <= cfgWrData[FAC_W-1:0];
    end
  end
  for (genvar gj = 0; gj < N_PER; gj++) begin : g_perFac
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) perFac[gj] <= '0;
      else if (cfgWrEn && cfgWrAddr == ADDR_W'(N_DUTY + gj)) perFac[gj] <= cfgWrData[FAC_W-1:0];
    end
  end
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clampHi <= '1;
      clampLo <= '0;
    end else if (cfgWrEn) begin
      if (cfgWrAddr == ADDR_W'(HI_ADDR)) clampHi <= cfgWrData;
      if (cfgWrAddr == ADDR_W'(LO_ADDR)) clampLo <= cfgWrData;
    end
  end

  // shared multiplier with per-pass factor selection
  logic [FAC_W-1:0]         factor;
  logic signed [PROD_W-1:0] filtSx, facZx, prod;
  logic [MAG_W-1:0]         mag;
  logic [OUT_W:0]           rndTop;
  logic [OUT_W-1:0]         rounded, afterHi, dutyClamped;

  always_comb begin
    factor  = strb.dutyPass ? dutyFac[dutySelR] : perFac[perSelR];
    filtSx  = {{FAC_W{filtReg[IN_W-1]}}, filtReg};
    facZx   = {{IN_W{1'b0}}, factor};
    prod    = filtSx * facZx;
    mag     = prod[PROD_W-1] ? '0 : prod[MAG_W-1:0];
    rndTop  = (OUT_W+1)'(({1'b0, mag} + HALF) >> SHIFT);
    rounded = rndTop[OUT_W] ? '1 : rndTop[OUT_W-1:0];
    afterHi     = (rounded > clampHi) ? clampHi : rounded;
    dutyClamped = (afterHi < clampLo) ? clampLo : afterHi;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      filtReg   <= '0;
      dutySelR  <= '0;
      perSelR   <= '0;
      dutyHold  <= '0;
      dutyOut   <= '0;
      periodOut <= '0;
    end else begin
      if (strb.capture) begin
        filtReg  <= filterIn;
        dutySelR <= dutySel;
        perSelR  <= periodSel;
      end
      if (strb.dutyPass) dutyHold <= dutyClamped;
      if (strb.periodPass) begin
        dutyOut   <= dutyHold;
        periodOut <= rounded[OUT_W-1:FRAC_W];
      end
    end
  end

  // R7: held duty value respects the ceiling unless the floor overrides it
  p_duty_ceiling_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.dutyPass |=> (dutyHold <= $past(clampHi)) || ($past(clampLo) > $past(clampHi)));

  // R7: held duty value never sits below the floor
  p_duty_floor_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.dutyPass |=> dutyHold >= $past(clampLo));

  // R5: a negative operand yields a zero period
  p_neg_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.periodPass && filtReg[IN_W-1] |=> periodOut == '0);

  // R11: outputs only move on the period pass
  p_outputs_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !strb.periodPass |=> $stable(dutyOut) && $stable(periodOut));
endmodule

// File: rtl/filter_out_scaler.sv
`timescale 1ns/1ps
module filter_out_scaler
  import fos_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic [2:0]  cfgWrAddr,
  input  logic [17:0] cfgWrData,
  input  logic        start,
  input  logic [23:0] filterIn,
  input  logic [1:0]  dutySel,
  input  logic        periodSel,
  output logic [17:0] dutyOut,
  output logic [13:0] periodOut,
  output logic        done
);
  fosStrobe_t strb;

  fos_ctrl u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .start (start),
    .strb  (strb),
    .done  (done)
  );

  fos_datapath #(
    .IN_W   (24),
    .FAC_W  (14),
    .OUT_W  (18),
    .FRAC_W (4),
    .N_DUTY (4),
    .N_PER  (2)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .cfgWrEn   (cfgWrEn),
    .cfgWrAddr (cfgWrAddr),
    .cfgWrData (cfgWrData),
    .filterIn  (filterIn),
    .dutySel   (dutySel),
    .periodSel (periodSel),
    .dutyOut   (dutyOut),
    .periodOut (periodOut)
  );
endmodule

// File: tb/sim_filter_out_scaler.sv
`timescale 1ns/1ps
module sim_filter_out_scaler;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [2:0]  cfgWrAddr = '0;
  logic [17:0] cfgWrData = '0;
  logic        start = 1'b0;
  logic [23:0] filterIn = '0;
  logic [1:0]  dutySel = '0;
  logic        periodSel = 1'b0;
  logic [17:0] dutyOut;
  logic [13:0] periodOut;
  logic        done;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  // bench shadow of configuration
  longint dFac [4];
  longint pFac [2];
  longint cHi = 'h3FFFF;
  longint cLo = 0;

  always #2.5 clk = ~clk;

  filter_out_scaler u0 (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrAddr(cfgWrAddr),
    .cfgWrData(cfgWrData), .start(start), .filterIn(filterIn),
    .dutySel(dutySel), .periodSel(periodSel), .dutyOut(dutyOut),
    .periodOut(periodOut), .done(done)
  );

  function automatic longint roundIt(input logic [23:0] f, input longint k);
    longint p;
    p = longint'($signed(f)) * k;
    if (p < 0) p = 0;
    p = (p + (longint'(1) << 18)) >>> 19;
    if (p > 'h3FFFF) p = 'h3FFFF;
    return p;
  endfunction

  function automatic longint clampIt(input longint v);
    longint r;
    r = (v > cHi) ? cHi : v;
    if (r < cLo) r = cLo;
    return r;
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic cfgWrite(input int addr, input longint data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrAddr = 3'(addr); cfgWrData = 18'(data);
    @(negedge clk);
    cfgWrEn = 1'b0;
    if (addr < 4) dFac[addr] = data & 'h3FFF;
    else if (addr < 6) pFac[addr-4] = data & 'h3FFF;
    else if (addr == 6) cHi = data & 'h3FFFF;
    else cLo = data & 'h3FFFF;
  endtask

  // one conversion; expected values computed from the shadow at start
  task automatic runOp(input logic [23:0] f, input logic [1:0] ds, input logic ps,
                       input bit poke, input string req);
    longint expDuty, expPer;
    expDuty = clampIt(roundIt(f, dFac[ds]));
    expPer  = roundIt(f, pFac[ps]) >> 4;
    @(negedge clk);
    filterIn = f; dutySel = ds; periodSel = ps; start = 1'b1;
    @(negedge clk);
    start = poke; filterIn = ~f; dutySel = ~ds; periodSel = ~ps;
    check({req, " R3 done low after start"}, longint'(done), 0);
    @(negedge clk);
    start = 1'b0; filterIn = $urandom; dutySel = 2'($urandom); periodSel = 1'($urandom);
    check({req, " R3 done low in duty pass"}, longint'(done), 0);
    @(negedge clk);
    check({req, " R3 done asserted"}, longint'(done), 1);
    check({req, " duty"}, longint'(dutyOut), expDuty);
    check({req, " period"}, longint'(periodOut), expPer);
    @(negedge clk);
    check({req, " R11 R4 single done"}, longint'(done), 0);
    check({req, " R11 duty hold"}, longint'(dutyOut), expDuty);
    check({req, " R11 period hold"}, longint'(periodOut), expPer);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < 4; i++) dFac[i] = 0;
    for (int i = 0; i < 2; i++) pFac[i] = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 dutyOut reset", longint'(dutyOut), 0);
    check("R1 periodOut reset", longint'(periodOut), 0);
    check("R1 done reset", longint'(done), 0);
    runOp(24'h400000, 2'd0, 1'b0, 1'b0, "R1 zero factors");

    // R10 worked example, R2 write, R1 default ceiling does not clamp
    cfgWrite(0, 2500);
    cfgWrite(4, 2500);
    runOp(24'h400000, 2'd0, 1'b0, 1'b0, "R10 R2 example");
    check("R10 duty literal", longint'(dutyOut), 'h4E20);
    check("R10 period literal", longint'(periodOut), 'h4E2);

    // R5 negative operand
    runOp(24'hC00000, 2'd0, 1'b0, 1'b0, "R5 negative");
    runOp(24'h800000, 2'd0, 1'b0, 1'b0, "R5 most negative");

    // R6 half-LSB boundary: 32*8192 = 2^18 rounds to 1, 32*8191 rounds to 0
    cfgWrite(1, 8192);
    cfgWrite(2, 8191);
    runOp(24'd32, 2'd1, 1'b0, 1'b0, "R6 half up");
    check("R6 half literal", longint'(dutyOut), 1);
    runOp(24'd32, 2'd2, 1'b0, 1'b0, "R6 below half");
    check("R6 below literal", longint'(dutyOut), 0);
    // R6 largest magnitude, R8 period has no clamp
    cfgWrite(3, 'h3FFF);
    cfgWrite(5, 'h3FFF);
    runOp(24'h7FFFFF, 2'd3, 1'b1, 1'b0, "R6 R8 max");

    // R9 distinct factors per index
    cfgWrite(0, 100); cfgWrite(1, 200); cfgWrite(2, 300); cfgWrite(3, 400);
    cfgWrite(4, 1000); cfgWrite(5, 3000);
    for (int s = 0; s < 4; s++) runOp(24'h300000, 2'(s), 1'(s), 1'b0, "R9 select");

    // R7 clamps; R8 period unaffected by clamp
    cfgWrite(6, 1000);
    cfgWrite(7, 500);
    cfgWrite(0, 'h3FFF);
    runOp(24'h400000, 2'd0, 1'b1, 1'b0, "R7 R8 above ceiling");
    check("R7 ceiling literal", longint'(dutyOut), 1000);
    runOp(24'h000100, 2'd0, 1'b0, 1'b0, "R7 below floor");
    check("R7 floor literal", longint'(dutyOut), 500);
    cfgWrite(6, 300);
    cfgWrite(7, 700);
    runOp(24'h400000, 2'd0, 1'b0, 1'b0, "R7 floor over ceiling");
    check("R7 floor wins literal", longint'(dutyOut), 700);

    // R4 second start during a run, R3 operand change after start
    cfgWrite(6, 'h3FFFF);
    cfgWrite(7, 0);
    runOp(24'h123456, 2'd2, 1'b1, 1'b1, "R4 busy start");

    // random mix
    for (int n = 0; n < 250; n++) begin
      logic [23:0] f;
      int pick;
      pick = $urandom_range(0, 9);
      if (pick == 0) cfgWrite($urandom_range(0, 5), $urandom);
      else if (pick == 1) begin
        cfgWrite(6, $urandom_range(0, 'h3FFFF));
        cfgWrite(7, $urandom_range(0, 'h3FFFF));
      end else if (pick == 2) begin
        cfgWrite(6, 'h3FFFF);
        cfgWrite(7, 0);
      end
      case ($urandom_range(0, 3))
        0: f = 24'h7FFFFF - 24'($urandom_range(0, 255));
        1: f = 24'h800000 + 24'($urandom_range(0, 255));
        default: f = 24'($urandom);
      endcase
      runOp(f, 2'($urandom), 1'($urandom), 1'($urandom), "R6 R7 R8 R9 random");
    end

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule